// File: doc/BRIEF.md
# Signed Multiplier with Condition Code

This block is the integer multiply unit of a processor execute stage. It takes two signed operands, forms their full double-width product one multiplier bit per cycle, and returns the product truncated to the operating width together with a 2-bit condition code. The condition code is judged on the untruncated product, so software can learn that the truncated result lost information.

Two operating widths are selected per operation. In narrow mode only the low half of each operand is used; both halves are sign-extended and a 64-bit product is formed. In wide mode the full 64-bit operands give a 128-bit product. A one-cycle `start_i` pulse latches the operands and the mode. `done_o` then pulses for one cycle, and from that cycle the result and condition code stay on their outputs until the next completion.

Top module: `smul_top`

## Requirements
- R1: In narrow mode (`wide_i`=0) `result_o[31:0]` equals the low 32 bits of the signed product of `op_a_i[31:0]` and `op_b_i[31:0]`, `result_o[63:32]` is zero, and `op_a_i[63:32]` and `op_b_i[63:32]` have no effect.
- R2: In wide mode (`wide_i`=1) `result_o` equals the low 64 bits of the 128-bit signed product of `op_a_i` and `op_b_i`.
- R3: `cc_o` is 0 exactly when the full product is zero. This test wins over every other code, so a product whose low half is zero but whose upper half is not does not give 0.
- R4: In narrow mode a non-zero product outside the signed 32-bit range (bits 63..31 of the 64-bit product not all equal) gives `cc_o` = 3.
- R5: In wide mode a non-zero product outside the signed 64-bit range (bits 127..63 of the 128-bit product not all equal) gives `cc_o` = 3. This includes the most-negative value times -1.
- R6: A product that is neither zero nor out of range gives `cc_o` = 1 when it is negative and 2 when it is positive. Exact range limits such as -2^31 in narrow mode and -2^63 in wide mode are in range.
- R7: `done_o` is high for exactly one cycle. It rises on the 33rd rising edge after the edge that accepts `start_i` in narrow mode, and on the 65th in wide mode.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. It does not change the running operation and produces no extra `done_o`.
- R9: While `rst_ni` is low, `busy_o`, `done_o`, `result_o` and `cc_o` are all zero.
- R10: `busy_o` is high from the edge that accepts `start_i` until the edge that raises `done_o`, and it is low in the cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the unit is idle |
| wide_i | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| op_a_i | input | 64 | Multiplicand |
| op_b_i | input | 64 | Multiplier |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse: result and code are valid |
| result_o | output | 64 | Truncated product |
| cc_o | output | 2 | 0 zero, 1 negative, 2 positive, 3 overflow |

## Verification
The hardest cases to reach are the edges of the condition-code priority. One is a product whose truncated half is all zeros while the discarded half is not. Another is a product sitting exactly on a signed range limit. A third is the most-negative operand times -1, where the subtracting sign step of the iteration must give a positive out-of-range value. Directed operations with hand-derived results hit each of these in both modes, with garbage placed in the ignored upper operand bits. A long random phase then issues starts at random times, many of them while busy, and draws operands from a pool weighted toward zero, -1 and the two most-negative values. A behavioural reference model checks every cycle.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [1:0] {
    CC_ZERO = 2'd0,
    CC_NEG  = 2'd1,
    CC_POS  = 2'd2,
    CC_OVF  = 2'd3
  } cc_e;
endpackage

// File: rtl/smul_iter.sv
module smul_iter #(
  parameter int XLEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              wide_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  output logic              run_o,
  output logic              fin_o,
  output logic              wide_o,
  output logic [2*XLEN-1:0] prod_o
);
  localparam int HALF  = XLEN / 2;
  localparam int PROD  = 2 * XLEN;
  localparam int CNT_W = $clog2(XLEN + 1);
  localparam logic [CNT_W-1:0] LAST_W = CNT_W'(XLEN - 1);
  localparam logic [CNT_W-1:0] LAST_N = CNT_W'(HALF - 1);

  logic [PROD-1:0]  acc_q, mcand_q, part;
  logic [XLEN-1:0]  mplier_q, a_ext, b_ext;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, fin_q, wide_q, last_step;

  always_comb begin
    a_ext = wide_i ? a_i : {{HALF{a_i[HALF-1]}}, a_i[HALF-1:0]};
    b_ext = wide_i ? b_i : {{HALF{b_i[HALF-1]}}, b_i[HALF-1:0]};
  end

  assign last_step = (cnt_q == (wide_q ? LAST_W : LAST_N));
  assign part      = mplier_q[0] ? mcand_q : '0;

  // two's complement multiplier: the sign bit weighs -2^(n-1), so the last step subtracts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      fin_q    <= 1'b0;
      wide_q   <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load_i) begin
        acc_q    <= '0;
        mcand_q  <= {{XLEN{a_ext[XLEN-1]}}, a_ext};
        mplier_q <= b_ext;
        cnt_q    <= '0;
        run_q    <= 1'b1;
        wide_q   <= wide_i;
      end else if (run_q) begin
        acc_q    <= last_step ? acc_q - part : acc_q + part;
        mcand_q  <= mcand_q << 1;
        mplier_q <= mplier_q >> 1;
        cnt_q    <= cnt_q + CNT_W'(1);
        if (last_step) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign run_o  = run_q;
  assign fin_o  = fin_q;
  assign wide_o = wide_q;
  assign prod_o = acc_q;

  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q <= LAST_W));
  assert_fin_after_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |-> !run_q);
  assert_mode_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q)) |-> $stable(wide_q));
endmodule

// File: rtl/smul_cc_eval.sv
module smul_cc_eval
  import smul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              wide_i,
  input  logic [2*XLEN-1:0] prod_i,
  output cc_e               cc_o,
  output logic [XLEN-1:0]   res_o
);
  localparam int HALF = XLEN / 2;
  localparam int PROD = 2 * XLEN;

  logic zero, ovf, neg;
  logic [XLEN-HALF:0] top_n;
  logic [PROD-XLEN:0] top_w;

  assign top_n = prod_i[XLEN-1:HALF-1];
  assign top_w = prod_i[PROD-1:XLEN-1];

  always_comb begin
    if (wide_i) begin
      zero = ~|prod_i;
      ovf  = !((&top_w) || (~|top_w));
      neg  = prod_i[PROD-1];
      res_o = prod_i[XLEN-1:0];
    end else begin
      zero = ~|prod_i[XLEN-1:0];
      ovf  = !((&top_n) || (~|top_n));
      neg  = prod_i[XLEN-1];
      res_o = {{(XLEN-HALF){1'b0}}, prod_i[HALF-1:0]};
    end
    if (zero)     cc_o = CC_ZERO;
    else if (ovf) cc_o = CC_OVF;
    else if (neg) cc_o = CC_NEG;
    else          cc_o = CC_POS;
  end
endmodule

// File: rtl/smul_top.sv
module smul_top
  import smul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            wide_i,
  input  logic [XLEN-1:0] op_a_i,
  input  logic [XLEN-1:0] op_b_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] result_o,
  output logic [1:0]      cc_o
);
  localparam int HALF = XLEN / 2;
  localparam int PROD = 2 * XLEN;

  logic            load, run, fin, wide_q;
  logic [PROD-1:0] prod;
  cc_e             cc_next;
  logic [XLEN-1:0] res_next;
  logic [XLEN-1:0] result_q;
  logic [1:0]      cc_q;
  logic            done_q;

  assign busy_o = run | fin;
  assign load   = start_i & ~busy_o;

  smul_iter #(.XLEN(XLEN)) i_iter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .wide_i (wide_i),
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .run_o  (run),
    .fin_o  (fin),
    .wide_o (wide_q),
    .prod_o (prod)
  );

  smul_cc_eval #(.XLEN(XLEN)) i_cc (
    .wide_i (wide_q),
    .prod_i (prod),
    .cc_o   (cc_next),
    .res_o  (res_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      cc_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= fin;
      if (fin) begin
        result_q <= res_next;
        cc_q     <= cc_next;
      end
    end
  end

  assign done_o   = done_q;
  assign result_o = result_q;
  assign cc_o     = cc_q;

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_zero_result_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cc_o == CC_ZERO) |-> (result_o == '0));
  assert_narrow_upper_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !wide_q) |-> (result_o[XLEN-1:HALF] == '0));
  assert_sign_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (cc_o == CC_NEG || cc_o == CC_POS)) |->
      ((cc_o == CC_NEG) == (wide_q ? result_o[XLEN-1] : result_o[HALF-1])));
  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && start_i) |=> (busy_o && !done_o));
endmodule

// File: tb/test_smul_top.sv
`timescale 1ns/1ps
module test_smul_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wide = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        busy, done;
  logic [63:0] result;
  logic [1:0]  cc;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #4 clk = ~clk;

  smul_top i_smul_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wide_i(wide),
    .op_a_i(op_a), .op_b_i(op_b), .busy_o(busy), .done_o(done),
    .result_o(result), .cc_o(cc)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic signed [127:0] full_prod(input bit w, input logic [63:0] a, input logic [63:0] b);
    logic signed [127:0] sa, sb;
    if (w) begin
      sa = $signed({{64{a[63]}}, a});
      sb = $signed({{64{b[63]}}, b});
    end else begin
      sa = $signed({{96{a[31]}}, a[31:0]});
      sb = $signed({{96{b[31]}}, b[31:0]});
    end
    return sa * sb;
  endfunction

  function automatic logic [1:0] ref_cc(input bit w, input logic signed [127:0] p);
    logic signed [127:0] hi, lo;
    hi = w ? ((128'sd1 <<< 63) - 128'sd1) : ((128'sd1 <<< 31) - 128'sd1);
    lo = -hi - 128'sd1;
    if (p == 0) return 2'd0;
    if (p > hi || p < lo) return 2'd3;
    if (p < 0) return 2'd1;
    return 2'd2;
  endfunction

  // reference model, advanced on each rising edge
  bit          m_busy, m_done, m_wide, p_wide;
  logic [63:0] m_res, p_res;
  logic [1:0]  m_cc, p_cc;
  int          m_left;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_res = '0; m_cc = '0; m_left = 0; m_wide = 0; p_wide = 0;
      p_res = '0; p_cc = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_res = p_res; m_cc = p_cc; m_wide = p_wide;
        end
      end else if (start) begin
        logic signed [127:0] p;
        p = full_prod(wide, op_a, op_b);
        m_busy = 1;
        m_left = (wide ? 64 : 32) + 1;
        p_wide = wide;
        p_res  = wide ? p[63:0] : {32'h0, p[31:0]};
        p_cc   = ref_cc(wide, p);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk(busy == m_busy, "R10 busy", 64'(busy), 64'(m_busy));
      chk(done == m_done, "R7 done", 64'(done), 64'(m_done));
      chk(result == m_res, m_wide ? "R2 result" : "R1 result", result, m_res);
      if (m_cc == 2'd0)      chk(cc == m_cc, "R3 cc", 64'(cc), 64'(m_cc));
      else if (m_cc == 2'd3) chk(cc == m_cc, m_wide ? "R5 cc" : "R4 cc", 64'(cc), 64'(m_cc));
      else                   chk(cc == m_cc, "R6 cc", 64'(cc), 64'(m_cc));
    end
  end

  task automatic run_op(input bit w, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] exp_res, input logic [1:0] exp_cc, input string tag);
    int cyc;
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1; wide = w; op_a = a; op_b = b;
    @(negedge clk);
    start = 0; op_a = $urandom(); op_b = $urandom(); wide = ~w;
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == (w ? 65 : 33), "R7 latency", 64'(cyc), 64'(w ? 65 : 33));
    chk(result == exp_res, {tag, " result"}, result, exp_res);
    chk(cc == exp_cc, {tag, " cc"}, 64'(cc), 64'(exp_cc));
    @(negedge clk);
    chk(done == 1'b0, "R7 single pulse", 64'(done), 64'd0);
  endtask

  function automatic logic [63:0] pick();
    case ($urandom_range(0, 6))
      0: return 64'h0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'hFFFF_FFFF_8000_0000;
      4: return 64'($urandom_range(0, 40)) - 64'd20;
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, result, cc} == '0, "R9 reset state", result, 64'h0);
    rst_n = 1;
    // R1 R4: MIN32 * -1, upper operand bits garbage
    run_op(0, 64'h1234_5678_8000_0000, 64'hABCD_0000_FFFF_FFFF, 64'h0000_0000_8000_0000, 2'd3, "R4 min32");
    // R3 priority: low half zero but product nonzero
    run_op(0, 64'hDEAD_BEEF_0001_0000, 64'h0000_0000_0001_0000, 64'h0, 2'd3, "R3 low-zero narrow");
    run_op(0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'd0, "R3 zero narrow");
    run_op(0, 64'h0000_0000_4000_0000, 64'h0000_0000_FFFF_FFFE, 64'h0000_0000_8000_0000, 2'd1, "R6 limit narrow");
    run_op(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_FFFF_FFFF, 64'h1, 2'd2, "R1 neg*neg");
    run_op(1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 2'd3, "R5 min64");
    run_op(1, 64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 64'h0, 2'd3, "R3 low-zero wide");
    run_op(1, 64'h4000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFE, 64'h8000_0000_0000_0000, 2'd1, "R6 limit wide");
    run_op(1, 64'd7, 64'hFFFF_FFFF_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFEB, 2'd1, "R2 neg");
    run_op(1, 64'd3, 64'd5, 64'd15, 2'd2, "R2 pos");
    // R8: start while busy is ignored
    @(negedge clk);
    start = 1; wide = 1; op_a = 64'd6; op_b = 64'd9;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    start = 1; wide = 0; op_a = 64'd0; op_b = 64'd0;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    chk(result == 64'd54, "R8 result kept", result, 64'd54);
    chk(cc == 2'd2, "R8 cc kept", 64'(cc), 64'd2);
    repeat (40) begin
      @(negedge clk);
      chk(done == 1'b0, "R8 no extra done", 64'(done), 64'd0);
    end
    // R9: reset in mid operation
    start = 1; wide = 1; op_a = 64'd11; op_b = 64'd13;
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk({busy, done, result, cc} == '0, "R9 mid-op reset", result, 64'h0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({busy, done, result, cc} == '0, "R9 after release", result, 64'h0);
    // random phase, model compared each cycle
    repeat (20000) begin
      @(negedge clk);
      start = ($urandom_range(0, 9) < 2);
      wide  = $urandom_range(0, 1);
      op_a  = pick();
      op_b  = pick();
    end
    start = 0;
    repeat (80) @(negedge clk);
    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule